// File: doc/BRIEF.md
# Multi-Mode Video Timing Generator

This block drives the raster timing for a 640-pixel-wide progressive display. On every pixel clock it advances a horizontal pixel counter and a vertical line counter. From their values and the timing of the selected mode it produces active-low horizontal and vertical sync, an active-high data enable, a blanking flag that the pixel path uses to force black, a one-clock black-level clamp strobe, and the column and row of the current active pixel.

Five timing sets are built in. They share the 640-pixel active width but differ in their porch, sync and total counts, and their active height is either 480 or 400 lines. A four-bit mode code picks the set. The code is read only when the raster wraps from the last pixel of the last line back to the origin. A change applied in mid-frame therefore never produces a short or malformed frame. The first clock after reset counts as such a wrap, so the code present at reset release sets the timing of the first frame.

The active width and the two active heights are parameters, so that scaled-down rasters can be used for fast simulation. Porch, sync and clamp counts stay fixed per mode.

Top module: `video_timing_gen`

## Requirements
- R1: While reset is asserted, hsync_n_o and vsync_n_o are 1, de_o and clamp_o are 0, blank_o is 1, and x_o and y_o are 0.
- R2: Horizontal timing, with pixel 0 at the hsync falling edge: hsync_n_o is low for pixels 0 to HS-1. de_o can be high only for the ACT_W pixels that start at pixel HS+HB. The line lasts HS+HB+ACT_W+HF clocks. The (HF, HS, HB) values are (16, 96, 48) for modes 0, 1 and 2, (64, 64, 80) for mode 3, and (64, 64, 96) for mode 4.
- R3: Vertical timing, with line 0 holding the vsync fall: vsync_n_o is low for VS lines. Active lines run from line VS+VB for VA lines, and the frame lasts VS+VB+VA+VF lines. The (VF, VS, VB, VA) values are: mode 0 (11, 2, 32, ACT_TALL); mode 1 (12, 2, 35, ACT_SHORT); mode 2 (6, 2, 37, ACT_TALL); mode 3 (7, 8, 25, ACT_SHORT); mode 4 (3, 3, 39, ACT_TALL).
- R4: Both edges of vsync_n_o occur at pixel 1, one clock after the hsync falling edge. The fall is on line 0 and the rise is on line VS.
- R5: clamp_o is high for exactly one clock in every line, at pixel 18 in modes 0, 1, 2 and 4 and at pixel 15 in mode 3.
- R6: de_o is high only when the pixel is inside both the horizontal and the vertical active windows. blank_o is always the inverse of de_o.
- R7: x_o equals the pixel index minus HS+HB while de_o is high and is 0 otherwise. y_o equals the line index minus VS+VB for the whole of each active line and is 0 on other lines.
- R8: Mode codes 0 to 4 select the timing sets of R2 to R5. Codes 5 to 15 select the mode 0 timing.
- R9: mode_i is sampled only on the clock that wraps the raster to pixel 0 of line 0, and on the first clock after reset. Changes at other times have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Timing mode code |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Data enable, high on active pixels |
| blank_o | output | 1 | High where the pixel path must output black |
| clamp_o | output | 1 | One-clock black-level clamp strobe |
| x_o | output | $clog2(ACT_W) | Active column |
| y_o | output | $clog2(ACT_TALL) | Active row |

## Verification
Some properties hold whatever the mode, and the assertions check these on every cycle:
- the raster counters stay inside the current line and frame lengths;
- de_o never overlaps either sync pulse;
- the clamp strobe sits inside hsync and is one clock wide;
- x_o steps by one across an active run;
- vsync_n_o only moves at pixel 1;
- a new mode appears only at the raster origin.

The exact interval lengths of each timing set need the bench's scenarios. So do the fallback of unused codes and the proof that a mid-frame code change leaves the running frame untouched. For these, the bench predicts every output on every clock of whole frames from the mode tables.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int CNT_W     = 12;
  localparam int MODE_W    = 4;
  localparam int IDX_W     = 3;
  localparam int NUM_MODES = 5;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [IDX_W-1:0] idx_t;

  // Timing fields needed to place the output edges (front porches only enter the totals)
  typedef struct packed {
    cnt_t h_sync;
    cnt_t h_back;
    cnt_t h_act;
    cnt_t v_sync;
    cnt_t v_back;
    cnt_t v_act;
    cnt_t clamp;
  } vtg_view_t;

  // Unused codes fall back to index 0
  function automatic idx_t vtg_decode(input logic [MODE_W-1:0] code);
    return (int'(code) < NUM_MODES) ? idx_t'(code) : idx_t'(0);
  endfunction

  function automatic cnt_t vtg_hfront(input idx_t m);
    case (m)
      3'd3, 3'd4: return cnt_t'(64);
      default:    return cnt_t'(16);
    endcase
  endfunction

  function automatic cnt_t vtg_hsync(input idx_t m);
    case (m)
      3'd3, 3'd4: return cnt_t'(64);
      default:    return cnt_t'(96);
    endcase
  endfunction

  function automatic cnt_t vtg_hback(input idx_t m);
    case (m)
      3'd3:    return cnt_t'(80);
      3'd4:    return cnt_t'(96);
      default: return cnt_t'(48);
    endcase
  endfunction

  function automatic cnt_t vtg_vfront(input idx_t m);
    case (m)
      3'd1:    return cnt_t'(12);
      3'd2:    return cnt_t'(6);
      3'd3:    return cnt_t'(7);
      3'd4:    return cnt_t'(3);
      default: return cnt_t'(11);
    endcase
  endfunction

  function automatic cnt_t vtg_vsync(input idx_t m);
    case (m)
      3'd3:    return cnt_t'(8);
      3'd4:    return cnt_t'(3);
      default: return cnt_t'(2);
    endcase
  endfunction

  function automatic cnt_t vtg_vback(input idx_t m);
    case (m)
      3'd1:    return cnt_t'(35);
      3'd2:    return cnt_t'(37);
      3'd3:    return cnt_t'(25);
      3'd4:    return cnt_t'(39);
      default: return cnt_t'(32);
    endcase
  endfunction

  function automatic cnt_t vtg_clamp(input idx_t m);
    return (m == 3'd3) ? cnt_t'(15) : cnt_t'(18);
  endfunction

  function automatic cnt_t vtg_vact(input idx_t m, input int act_tall, input int act_short);
    return ((m == 3'd1) || (m == 3'd3)) ? cnt_t'(act_short) : cnt_t'(act_tall);
  endfunction

  function automatic cnt_t vtg_hlast(input idx_t m, input int act_w);
    return vtg_hsync(m) + vtg_hback(m) + cnt_t'(act_w) + vtg_hfront(m) - cnt_t'(1);
  endfunction

  function automatic cnt_t vtg_vlast(input idx_t m, input int act_tall, input int act_short);
    return vtg_vsync(m) + vtg_vback(m) + vtg_vact(m, act_tall, act_short)
           + vtg_vfront(m) - cnt_t'(1);
  endfunction

  function automatic vtg_view_t vtg_view(input idx_t m, input int act_w,
                                         input int act_tall, input int act_short);
    vtg_view_t v;
    v.h_sync = vtg_hsync(m);
    v.h_back = vtg_hback(m);
    v.h_act  = cnt_t'(act_w);
    v.v_sync = vtg_vsync(m);
    v.v_back = vtg_vback(m);
    v.v_act  = vtg_vact(m, act_tall, act_short);
    v.clamp  = vtg_clamp(m);
    return v;
  endfunction
endpackage

// File: rtl/vtg_mode_ctrl.sv
module vtg_mode_ctrl
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              frame_end_i,
  output idx_t              idx_q_o,
  output idx_t              idx_d_o
);
  idx_t idx_q;
  idx_t idx_d;

  always_comb begin
    idx_d = frame_end_i ? vtg_decode(mode_i) : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (frame_end_i) begin
      idx_q <= idx_d;
    end
  end

  assign idx_q_o = idx_q;
  assign idx_d_o = idx_d;
endmodule

// File: rtl/vtg_raster.sv
module vtg_raster
  import vtg_pkg::*;
#(
  parameter cnt_t RST_H = '0,
  parameter cnt_t RST_V = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  cnt_t h_last_i,
  input  cnt_t v_last_i,
  output cnt_t h_q_o,
  output cnt_t v_q_o,
  output cnt_t h_d_o,
  output cnt_t v_d_o,
  output logic frame_end_o
);
  cnt_t h_q, v_q, h_d, v_d;
  logic line_end, frame_end;

  always_comb begin
    line_end  = (h_q == h_last_i);
    frame_end = line_end && (v_q == v_last_i);
    h_d       = line_end ? '0 : h_q + cnt_t'(1);
    if (!line_end)      v_d = v_q;
    else if (frame_end) v_d = '0;
    else                v_d = v_q + cnt_t'(1);
  end

  // Reset parks the raster on the last pixel of the frame so the first edge is a wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= RST_H;
      v_q <= RST_V;
    end else begin
      h_q <= h_d;
      if (line_end) v_q <= v_d;
    end
  end

  assign h_q_o       = h_q;
  assign v_q_o       = v_q;
  assign h_d_o       = h_d;
  assign v_d_o       = v_d;
  assign frame_end_o = frame_end;

  // R2: pixel counter never passes the line length of the running mode
  a_r2_pixel_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    h_q <= h_last_i);
  // R3: line counter never passes the frame length of the running mode
  a_r3_line_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    v_q <= v_last_i);
endmodule

// File: rtl/vtg_sync_gen.sv
module vtg_sync_gen
  import vtg_pkg::*;
#(
  parameter int X_W = 10,
  parameter int Y_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  cnt_t           h_d_i,
  input  cnt_t           v_d_i,
  input  vtg_view_t      view_i,
  output logic           hsync_n_o,
  output logic           vsync_n_o,
  output logic           de_o,
  output logic           blank_o,
  output logic           clamp_o,
  output logic [X_W-1:0] x_o,
  output logic [Y_W-1:0] y_o
);
  cnt_t           h_first, v_first;
  logic           h_win, v_win;
  logic           hs_n_d, vs_n_d, de_d, clamp_d;
  logic [X_W-1:0] x_d;
  logic [Y_W-1:0] y_d;

  always_comb begin
    h_first = view_i.h_sync + view_i.h_back;
    v_first = view_i.v_sync + view_i.v_back;
    h_win   = (h_d_i >= h_first) && (h_d_i < h_first + view_i.h_act);
    v_win   = (v_d_i >= v_first) && (v_d_i < v_first + view_i.v_act);
    de_d    = h_win && v_win;
    hs_n_d  = (h_d_i >= view_i.h_sync);
    // vertical pulse shifted by one pixel so it trails the hsync fall
    if (h_d_i == '0) vs_n_d = !((v_d_i != '0) && (v_d_i <= view_i.v_sync));
    else             vs_n_d = (v_d_i >= view_i.v_sync);
    clamp_d = (h_d_i == view_i.clamp);
    x_d     = de_d  ? X_W'(h_d_i - h_first) : '0;
    y_d     = v_win ? Y_W'(v_d_i - v_first) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_n_o <= 1'b1;
      vsync_n_o <= 1'b1;
      de_o      <= 1'b0;
      blank_o   <= 1'b1;
      clamp_o   <= 1'b0;
      x_o       <= '0;
      y_o       <= '0;
    end else begin
      hsync_n_o <= hs_n_d;
      vsync_n_o <= vs_n_d;
      de_o      <= de_d;
      blank_o   <= !de_d;
      clamp_o   <= clamp_d;
      x_o       <= x_d;
      y_o       <= y_d;
    end
  end

  // R6: data enable never overlaps either sync pulse
  a_r6_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> (hsync_n_o && vsync_n_o));
  // R5: clamp strobe lies inside the horizontal sync pulse
  a_r5_clamp_in_hsync: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_o |-> !hsync_n_o);
  // R5: clamp strobe lasts one clock
  a_r5_clamp_single: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_o |=> !clamp_o);
  // R7: column advances by one inside an active run
  a_r7_x_steps: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |=> (!de_o || (x_o == X_W'($past(x_o) + 1'b1))));
endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter  int ACT_W     = 640,
  parameter  int ACT_TALL  = 480,
  parameter  int ACT_SHORT = 400,
  localparam int X_W       = $clog2(ACT_W),
  localparam int Y_W       = $clog2(ACT_TALL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  output logic              hsync_n_o,
  output logic              vsync_n_o,
  output logic              de_o,
  output logic              blank_o,
  output logic              clamp_o,
  output logic [X_W-1:0]    x_o,
  output logic [Y_W-1:0]    y_o
);
  localparam cnt_t RST_H = vtg_hlast(idx_t'(0), ACT_W);
  localparam cnt_t RST_V = vtg_vlast(idx_t'(0), ACT_TALL, ACT_SHORT);

  idx_t      idx_q, idx_d;
  cnt_t      h_last, v_last;
  cnt_t      h_q, v_q, h_d, v_d;
  logic      frame_end;
  vtg_view_t view_d;

  always_comb begin
    h_last = vtg_hlast(idx_q, ACT_W);
    v_last = vtg_vlast(idx_q, ACT_TALL, ACT_SHORT);
    view_d = vtg_view(idx_d, ACT_W, ACT_TALL, ACT_SHORT);
  end

  vtg_mode_ctrl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .frame_end_i (frame_end),
    .idx_q_o     (idx_q),
    .idx_d_o     (idx_d)
  );

  vtg_raster #(.RST_H(RST_H), .RST_V(RST_V)) u_raster (
    .clk         (clk),
    .rst_n       (rst_n),
    .h_last_i    (h_last),
    .v_last_i    (v_last),
    .h_q_o       (h_q),
    .v_q_o       (v_q),
    .h_d_o       (h_d),
    .v_d_o       (v_d),
    .frame_end_o (frame_end)
  );

  vtg_sync_gen #(.X_W(X_W), .Y_W(Y_W)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_d_i     (h_d),
    .v_d_i     (v_d),
    .view_i    (view_d),
    .hsync_n_o (hsync_n_o),
    .vsync_n_o (vsync_n_o),
    .de_o      (de_o),
    .blank_o   (blank_o),
    .clamp_o   (clamp_o),
    .x_o       (x_o),
    .y_o       (y_o)
  );

  // R4: vertical sync moves only one clock after the line start
  a_r4_vsync_at_pixel1: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_n_o != $past(vsync_n_o)) |-> (h_q == cnt_t'(1)));
  // R9: a new timing set is only ever seen at the raster origin
  a_r9_switch_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != $past(idx_q)) |-> ((h_q == '0) && (v_q == '0)));
endmodule

// File: tb/sim_video_timing_gen.sv
module sim_video_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int AT = 8;
  localparam int AS = 6;
  localparam int XW = $clog2(AW);
  localparam int YW = $clog2(AT);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3:0]    mode;
  logic          hs_n, vs_n, de, blank, clamp;
  logic [XW-1:0] x;
  logic [YW-1:0] y;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int bad [7];
  int fa  [7];
  int fe  [7];

  video_timing_gen #(.ACT_W(AW), .ACT_TALL(AT), .ACT_SHORT(AS)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .hsync_n_o(hs_n), .vsync_n_o(vs_n), .de_o(de), .blank_o(blank),
    .clamp_o(clamp), .x_o(x), .y_o(y)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic note(input int k, input int a, input int e);
    if (a != e) begin
      if (bad[k] == 0) begin fa[k] = a; fe[k] = e; end
      bad[k]++;
    end
  endtask

  // R1: outputs while reset is held
  task automatic test_reset(input logic [3:0] first_code);
    rst_n = 1'b0;
    mode  = 4'd7;
    repeat (3) @(negedge clk);
    check(hs_n == 1'b1,  "R1 hsync_n in reset", int'(hs_n), 1);
    check(vs_n == 1'b1,  "R1 vsync_n in reset", int'(vs_n), 1);
    check(de == 1'b0,    "R1 de in reset", int'(de), 0);
    check(blank == 1'b1, "R1 blank in reset", int'(blank), 1);
    check(clamp == 1'b0, "R1 clamp in reset", int'(clamp), 0);
    check(x == '0,       "R1 x in reset", int'(x), 0);
    check(y == '0,       "R1 y in reset", int'(y), 0);
    mode = first_code;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R2 R3 R4 R5 R6 R7 R8 R9: predict every output over one whole frame
  task automatic run_frame(input logic [3:0] code, input logic [3:0] decoy,
                           input logic [3:0] next_code);
    int hf, hs, hb, vf, vs, vb, va, cl, ht, vt, h1, v1;
    string nm [7];
    nm = '{"R2 hsync_n", "R3 R4 vsync_n", "R2 R3 R6 de", "R6 blank",
           "R5 clamp", "R7 x", "R7 y"};
    hf = 16; hs = 96; hb = 48; vf = 11; vs = 2; vb = 32; va = AT; cl = 18;
    case (code)
      4'd1: begin vf = 12; vb = 35; va = AS; end
      4'd2: begin vf = 6;  vb = 37; end
      4'd3: begin hf = 64; hs = 64; hb = 80; vf = 7; vs = 8; vb = 25; va = AS; cl = 15; end
      4'd4: begin hf = 64; hs = 64; hb = 96; vf = 3; vs = 3; vb = 39; end
      default: ;
    endcase
    ht = hs + hb + AW + hf;
    vt = vs + vb + va + vf;
    h1 = hs + hb;
    v1 = vs + vb;
    for (int k = 0; k < 7; k++) begin bad[k] = 0; fa[k] = 0; fe[k] = 0; end
    for (int l = 0; l < vt; l++) begin
      for (int p = 0; p < ht; p++) begin
        bit hw, vw, ed, ev;
        @(posedge clk);
        @(negedge clk);
        hw = (p >= h1) && (p < h1 + AW);
        vw = (l >= v1) && (l < v1 + va);
        ed = hw && vw;
        ev = (p == 0) ? !((l >= 1) && (l <= vs)) : !(l < vs);
        note(0, int'(hs_n), (p < hs) ? 0 : 1);
        note(1, int'(vs_n), int'(ev));
        note(2, int'(de), int'(ed));
        note(3, int'(blank), int'(!ed));
        note(4, int'(clamp), (p == cl) ? 1 : 0);
        note(5, int'(x), ed ? p - h1 : 0);
        note(6, int'(y), vw ? l - v1 : 0);
        if ((l == vt / 2) && (p == 0)) mode = decoy;
        if ((l == vt - 1) && (p == ht - 1)) mode = next_code;
      end
    end
    for (int k = 0; k < 7; k++) begin
      check(bad[k] == 0, $sformatf("%s code %0d R8 R9 (%0d bad cycles)", nm[k], code, bad[k]),
            fa[k], fe[k]);
    end
  endtask

  initial begin
    test_reset(4'd0);
    run_frame(4'd0,  4'd3, 4'd1);
    run_frame(4'd1,  4'd4, 4'd2);
    run_frame(4'd2,  4'd0, 4'd3);
    run_frame(4'd3,  4'd1, 4'd4);
    run_frame(4'd4,  4'd2, 4'd9);
    run_frame(4'd9,  4'd3, 4'd15);
    run_frame(4'd15, 4'd4, 4'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule